// File: doc/BRIEF.md
# Per-Task Hardware Return Stack

This block holds one small last-in, first-out stack for each of the four hardware tasks of a processor core. A call pushes a packed word with the return address, the two condition flags and the execution-mode bit. A return pops that word and hands back the program counter and mode bit. Each condition flag is handed back only when the instruction asks for it. Generic push and pop let software move any 32-bit value through the same stack, for example to pull a return address into a register. A peek reads the top entry and leaves the stack as it is.

The task ID that comes with each operation picks the stack. Every operation takes a single clock. All results are combinational in the cycle of the strobe, and the stack update lands at the next rising edge. A stack never spills to memory. A push onto a full stack drops the oldest entry. A read from an empty stack returns zero. A status pulse marks each of these cases.

Top module: `task_ret_stack`

## Requirements
- R1: A synchronous reset, active high, empties all four stacks. After reset, a peek, pop or return on any task returns zero and raises `underflow`.
- R2: A call pushes the word whose bits 15:0 hold `pc_in`, bit 16 holds `c_in`, bit 17 holds `z_in` and bit 18 holds `mode_in`. Bits 31:19 are zero.
- R3: In the cycle of a return, `pc_out` and `mode_out` take bits 15:0 and bit 18 of the popped word. `z_out` takes bit 17 only when `wr_z` is high, and `c_out` takes bit 16 only when `wr_c` is high. Otherwise, and in any cycle without a return, the outputs follow `pc_in`, `mode_in`, `z_in` and `c_in`.
- R4: A generic push stores `push_data`. A generic pop returns the most recent entry on `pop_data` and removes it, so values come back in reverse order of entry.
- R5: A peek returns the top entry on `pop_data` and does not change the stack. A later peek or pop sees the same value.
- R6: Each task's stack is private. Operations on one task, in any order and in back-to-back cycles, never change what another task reads back.
- R7: A call or push onto a stack holding DEPTH entries (default 4) raises `overflow` in that cycle, discards the oldest entry and stores the new one on top.
- R8: A peek, pop or return on an empty stack returns zero on `pop_data` and raises `underflow` in that cycle. The stack stays empty.
- R9: Each operation finishes in one clock. Its result appears in the cycle of its strobe, and an operation in the next cycle already sees the updated stack.
- R10: When more than one of the five operation strobes is high, `op_clash` goes high and no operation takes place. The stacks are unchanged, `pop_data` is zero, no status flag rises, and the PC, mode and flag outputs follow their inputs.
- R11: When no strobe is high, `pop_data` is zero and `overflow`, `underflow` and `op_clash` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| task_id | input | 2 | Task that owns this cycle's operation |
| op_call | input | 1 | Push a packed return word |
| op_ret | input | 1 | Pop and restore PC, mode and optionally flags |
| op_push | input | 1 | Push `push_data` |
| op_pop | input | 1 | Pop top entry onto `pop_data` |
| op_peek | input | 1 | Read top entry without popping |
| push_data | input | 32 | Operand for a generic push |
| pc_in | input | 16 | Current program counter |
| mode_in | input | 1 | Current execution-mode bit |
| z_in | input | 1 | Current Z flag |
| c_in | input | 1 | Current C flag |
| wr_z | input | 1 | Restore Z on a return |
| wr_c | input | 1 | Restore C on a return |
| pop_data | output | 32 | Entry read by pop, peek or return |
| pc_out | output | 16 | Restored or passed-through PC |
| mode_out | output | 1 | Restored or passed-through mode bit |
| z_out | output | 1 | Restored or passed-through Z flag |
| c_out | output | 1 | Restored or passed-through C flag |
| overflow | output | 1 | Push or call discarded the oldest entry |
| underflow | output | 1 | Read from an empty stack |
| op_clash | output | 1 | More than one strobe; cycle ignored |

## Verification
Overflow and underflow never share a cycle. The interesting coincidence is a full-stack drop happening in the same cycle as another task's read, or a return with partial flag restore landing straight after a wrapped push. Sweeps therefore fill each task past its depth and drain it past empty, with tasks interleaved cycle by cycle. Clashing strobe pairs are also driven, and the stack contents are probed afterwards. Each cycle's outputs are judged against a per-task arithmetic model.

// File: rtl/task_ret_stack.sv
module task_ret_stack #(
  parameter int TASKS = 4,
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  parameter int PCW   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(TASKS)-1:0] task_id,
  input  logic                     op_call,
  input  logic                     op_ret,
  input  logic                     op_push,
  input  logic                     op_pop,
  input  logic                     op_peek,
  input  logic [WIDTH-1:0]         push_data,
  input  logic [PCW-1:0]           pc_in,
  input  logic                     mode_in,
  input  logic                     z_in,
  input  logic                     c_in,
  input  logic                     wr_z,
  input  logic                     wr_c,
  output logic [WIDTH-1:0]         pop_data,
  output logic [PCW-1:0]           pc_out,
  output logic                     mode_out,
  output logic                     z_out,
  output logic                     c_out,
  output logic                     overflow,
  output logic                     underflow,
  output logic                     op_clash
);
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int C_BIT = PCW;
  localparam int Z_BIT = PCW + 1;
  localparam int M_BIT = PCW + 2;

  logic [WIDTH-1:0] mem  [TASKS][DEPTH];
  logic [PW-1:0]    wptr [TASKS];
  logic [CW-1:0]    cnt  [TASKS];

  logic [4:0]       ops;
  logic             single, is_wr, is_rd, is_drop, do_ret, empty, full;
  logic [PW-1:0]    sel_ptr, top_idx, nxt_ptr;
  logic [WIDTH-1:0] call_word, wr_word, top_word;

  assign ops      = {op_call, op_ret, op_push, op_pop, op_peek};
  assign single   = $onehot(ops);
  assign op_clash = (ops != 5'd0) && !single;

  assign sel_ptr  = wptr[task_id];
  assign empty    = (cnt[task_id] == '0);
  assign full     = (cnt[task_id] == CW'(DEPTH));
  assign top_idx  = (sel_ptr == '0) ? PW'(DEPTH - 1) : sel_ptr - 1'b1;
  assign nxt_ptr  = (sel_ptr == PW'(DEPTH - 1)) ? '0 : sel_ptr + 1'b1;

  assign is_wr    = single && (op_call || op_push);
  assign is_rd    = single && (op_ret || op_pop || op_peek);
  assign is_drop  = single && (op_ret || op_pop);
  assign do_ret   = single && op_ret;

  assign call_word = {{(WIDTH - PCW - 3){1'b0}}, mode_in, z_in, c_in, pc_in};
  assign wr_word   = op_call ? call_word : push_data;
  assign top_word  = empty ? '0 : mem[task_id][top_idx];

  assign pop_data  = is_rd ? top_word : '0;
  assign underflow = is_rd && empty;
  assign overflow  = is_wr && full;

  assign pc_out   = do_ret ? top_word[PCW-1:0] : pc_in;
  assign mode_out = do_ret ? top_word[M_BIT]   : mode_in;
  assign z_out    = (do_ret && wr_z) ? top_word[Z_BIT] : z_in;
  assign c_out    = (do_ret && wr_c) ? top_word[C_BIT] : c_in;

  always_ff @(posedge clk) begin
    if (is_wr) mem[task_id][sel_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < TASKS; t++) begin
        wptr[t] <= '0;
        cnt[t]  <= '0;
      end
    end else if (is_wr) begin
      wptr[task_id] <= nxt_ptr;
      if (!full) cnt[task_id] <= cnt[task_id] + 1'b1;
    end else if (is_drop && !empty) begin
      wptr[task_id] <= top_idx;
      cnt[task_id]  <= cnt[task_id] - 1'b1;
    end
  end
endmodule

// File: rtl/task_ret_stack_chk.sv
module task_ret_stack_chk #(
  parameter int TW    = 2,
  parameter int WIDTH = 32,
  parameter int PCW   = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [TW-1:0]    task_id,
  input logic             op_call,
  input logic             op_ret,
  input logic             op_push,
  input logic             op_pop,
  input logic             op_peek,
  input logic             wr_z,
  input logic             z_in,
  input logic             z_out,
  input logic [PCW-1:0]   pc_in,
  input logic [PCW-1:0]   pc_out,
  input logic             mode_in,
  input logic             mode_out,
  input logic [WIDTH-1:0] pop_data,
  input logic             overflow,
  input logic             underflow,
  input logic             op_clash
);
  logic             one, none, last_rst, pk_v;
  logic [TW-1:0]    pk_t;
  logic [WIDTH-1:0] pk_d;

  assign one  = $countones({op_call, op_ret, op_push, op_pop, op_peek}) == 1;
  assign none = !(op_call || op_ret || op_push || op_pop || op_peek);

  always_ff @(posedge clk) begin
    last_rst <= rst;
    if (rst) pk_v <= 1'b0;
    else     pk_v <= one && op_peek;
    pk_t <= task_id;
    pk_d <= pop_data;
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    last_rst && one && (op_pop || op_peek || op_ret) |-> underflow && pop_data == '0); // R1
  AST_RET_KEEP_Z: assert property (@(posedge clk) disable iff (rst)
    one && op_ret && !wr_z |-> z_out == z_in); // R3
  AST_PEEK_STABLE: assert property (@(posedge clk) disable iff (rst)
    pk_v && one && op_peek && task_id == pk_t |-> pop_data == pk_d); // R5
  AST_OVF_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    overflow |-> one && (op_call || op_push)); // R7
  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (rst)
    underflow |-> pop_data == '0 && !overflow); // R8
  AST_CLASH_QUIET: assert property (@(posedge clk) disable iff (rst)
    op_clash |-> !overflow && !underflow && pop_data == '0 && pc_out == pc_in && mode_out == mode_in); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    none |-> !op_clash && !overflow && !underflow && pop_data == '0); // R11
endmodule

bind task_ret_stack task_ret_stack_chk #(.TW($clog2(TASKS)), .WIDTH(WIDTH), .PCW(PCW)) chk_i (
  .clk(clk), .rst(rst), .task_id(task_id), .op_call(op_call), .op_ret(op_ret),
  .op_push(op_push), .op_pop(op_pop), .op_peek(op_peek), .wr_z(wr_z), .z_in(z_in),
  .z_out(z_out), .pc_in(pc_in), .pc_out(pc_out), .mode_in(mode_in), .mode_out(mode_out),
  .pop_data(pop_data), .overflow(overflow), .underflow(underflow), .op_clash(op_clash)
);

// File: tb/task_ret_stack_tb.sv
module task_ret_stack_tb_top;
  localparam int DEPTH = 4;
  localparam logic [4:0] CALL = 5'b10000, RET = 5'b01000, PUSH = 5'b00100,
                         POP = 5'b00010, PEEK = 5'b00001, NONE = 5'b00000;

  logic        clk = 1'b0, rst = 1'b1;
  logic [1:0]  task_id = '0;
  logic        op_call = 0, op_ret = 0, op_push = 0, op_pop = 0, op_peek = 0;
  logic [31:0] push_data = '0;
  logic [15:0] pc_in = '0;
  logic        mode_in = 0, z_in = 0, c_in = 0, wr_z = 0, wr_c = 0;
  logic [31:0] pop_data;
  logic [15:0] pc_out;
  logic        mode_out, z_out, c_out, overflow, underflow, op_clash;

  int checks = 0, fails = 0;
  logic [31:0] mstk [4][DEPTH];
  int          mcnt [4];

  always #2 clk = ~clk;

  task_ret_stack dut_i (
    .clk(clk), .rst(rst), .task_id(task_id), .op_call(op_call), .op_ret(op_ret),
    .op_push(op_push), .op_pop(op_pop), .op_peek(op_peek), .push_data(push_data),
    .pc_in(pc_in), .mode_in(mode_in), .z_in(z_in), .c_in(c_in), .wr_z(wr_z), .wr_c(wr_c),
    .pop_data(pop_data), .pc_out(pc_out), .mode_out(mode_out), .z_out(z_out), .c_out(c_out),
    .overflow(overflow), .underflow(underflow), .op_clash(op_clash));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input string req, input int t, input logic [4:0] ops, input logic [31:0] d,
                       input logic [15:0] pc, input logic m, input logic z, input logic c,
                       input logic wz, input logic wc);
    logic single, rd, wrt, rt;
    logic [31:0] top, word;
    @(posedge clk); #1;
    task_id = 2'(t); {op_call, op_ret, op_push, op_pop, op_peek} = ops;
    push_data = d; pc_in = pc; mode_in = m; z_in = z; c_in = c; wr_z = wz; wr_c = wc;
    single = ($countones(ops) == 1);
    rd  = single && (ops[3] || ops[1] || ops[0]);
    wrt = single && (ops[4] || ops[2]);
    rt  = single && ops[3];
    top = (mcnt[t] == 0) ? 32'd0 : mstk[t][mcnt[t]-1];
    word = ops[4] ? (32'(pc) + 32'(c) * 65536 + 32'(z) * 131072 + 32'(m) * 262144) : d;
    @(negedge clk);
    chk(req, "pop_data",  pop_data,        rd ? top : 32'd0);
    chk(req, "underflow", 32'(underflow),  32'(rd && mcnt[t] == 0));
    chk(req, "overflow",  32'(overflow),   32'(wrt && mcnt[t] == DEPTH));
    chk(req, "op_clash",  32'(op_clash),   32'(!single && ops != 5'd0));
    chk(req, "pc_out",    32'(pc_out),     rt ? (top % 65536) : 32'(pc));
    chk(req, "mode_out",  32'(mode_out),   rt ? ((top / 262144) % 2) : 32'(m));
    chk(req, "z_out",     32'(z_out),      (rt && wz) ? ((top / 131072) % 2) : 32'(z));
    chk(req, "c_out",     32'(c_out),      (rt && wc) ? ((top / 65536) % 2) : 32'(c));
    if (wrt) begin
      if (mcnt[t] == DEPTH) begin
        for (int i = 0; i < DEPTH - 1; i++) mstk[t][i] = mstk[t][i+1];
        mcnt[t]--;
      end
      mstk[t][mcnt[t]] = word;
      mcnt[t]++;
    end else if (single && (ops[3] || ops[1]) && mcnt[t] > 0) begin
      mcnt[t]--;
    end
  endtask

  task automatic dat(input string req, input int t, input logic [4:0] ops, input logic [31:0] d);
    do_op(req, t, ops, d, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic apply_reset();
    @(posedge clk); #1;
    {op_call, op_ret, op_push, op_pop, op_peek} = NONE;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int t = 0; t < 4; t++) mcnt[t] = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < 4; t++) mcnt[t] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    for (int t = 0; t < 4; t++) dat("R1", t, PEEK, 0);
    dat("R11", 0, NONE, 32'h1234);

    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 8; k++) begin
        do_op("R2", t, CALL, 32'hFFFF_FFFF, 16'(16'h1003 * (t + 1) + 16'h0111 * k),
              k[2], k[1], k[0], 1'b0, 1'b0);
        dat("R2", t, POP, 0);
      end

    for (int w = 0; w < 4; w++)
      for (int k = 0; k < 8; k++) begin
        do_op("R3", w, CALL, 0, 16'(16'hA000 + k * 16'h0123 + w), k[2], k[1], k[0], 1'b0, 1'b0);
        do_op("R3", w, RET, 0, 16'h5555, ~k[2], ~k[1], ~k[0], w[1], w[0]);
      end
    do_op("R3", 1, NONE, 0, 16'hBEEF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);

    for (int t = 0; t < 4; t++)
      for (int n = 1; n <= DEPTH + 2; n++) begin
        for (int i = 0; i < n; i++) dat(n > DEPTH ? "R7" : "R4", t, PUSH, (t << 24) | (n << 8) | i);
        for (int i = 0; i <= n; i++) dat(i >= DEPTH ? "R8" : "R4", t, (i % 2) ? POP : RET, 0);
      end

    dat("R5", 3, PUSH, 32'hCAFE_0001);
    dat("R5", 3, PUSH, 32'hCAFE_0002);
    dat("R5", 3, PEEK, 0);
    dat("R5", 3, PEEK, 0);
    dat("R5", 3, POP, 0);
    dat("R5", 3, PEEK, 0);
    dat("R5", 3, POP, 0);
    dat("R8", 3, PEEK, 0);

    for (int i = 0; i < 3; i++)
      for (int t = 0; t < 4; t++) dat("R6", t, PUSH, 32'h6000_0000 | (t << 8) | i);
    for (int i = 0; i < 3; i++)
      for (int t = 3; t >= 0; t--) dat("R6", t, (t == 2) ? PEEK : POP, 0);
    for (int t = 0; t < 4; t++) dat("R6", t, POP, 0);

    dat("R9", 1, PUSH, 32'h9999_0001);
    do_op("R9", 1, RET, 0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    dat("R9", 1, PEEK, 0);

    dat("R10", 2, PUSH, 32'h1010_AAAA);
    dat("R10", 2, PUSH | POP, 32'h1010_BBBB);
    do_op("R10", 2, CALL | RET | PEEK, 0, 16'h7777, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    dat("R10", 2, PEEK, 0);
    dat("R10", 2, POP, 0);
    dat("R10", 2, POP, 0);

    for (int t = 0; t < 4; t++) dat("R1", t, PUSH, 32'hD00D_0000 | t);
    apply_reset();
    for (int t = 0; t < 4; t++) dat("R1", t, POP, 0);

    @(posedge clk); #1;
    {op_call, op_ret, op_push, op_pop, op_peek} = NONE;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule